// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Qualifier

This block compares the edges of a shared reference-divider pulse with the edges of two channel-divider pulses. Everything runs on the local oscillator clock, and all timing is measured in oscillator cycles. Each channel has an edge-triggered phase-frequency detector that raises an advance or retard command. One control bit swaps the sense of these commands so that a tuning element with a negative slope can be used.

Each channel has a lock qualifier. It counts how many oscillator cycles separate the two edges of each comparison. The channel is declared locked only after four tight comparisons in a row. A single loose comparison, or one edge waiting too long for its partner, withdraws lock at once.

A single lock pin is driven by a selector. In normal mode it can show the AND of both channels, either channel alone, or a constant high. A channel in standby counts as locked. In test mode the pin instead shows the raw edge strobes. A run flag for the reference divider drops only when both channels are in standby and the reference-off bit is set.

Top module: `dual_pfd_lock`

## Requirements
- R1: A rising edge on the reference pulse sets the channel's advance state, and a rising edge on its divider pulse sets the retard state. Each becomes visible on the outputs in the cycle after the sampling clock edge. When both are set, both clear on the next clock edge. Coincident edges therefore give a one-cycle pulse on both outputs, so there is no dead zone.
- R2: With invert_i at 1, up_o and dn_o of each channel swap roles. invert_i is a combinational select on the outputs.
- R3: The skew of a comparison is the number of clock cycles between the reference edge and the divider edge. A comparison qualifies when the skew is 0 or 1, that is, under two oscillator periods.
- R4: The lock indication of a channel rises in the cycle after the completion of its fourth consecutive qualifying comparison.
- R5: A comparison with a skew of 2 or more clears the qualifying count and the lock indication. A lone pending edge that has waited 3 or more clock edges does the same.
- R6: A channel in standby holds up_o and dn_o low, restarts its qualifier from zero, and reports its lock indication as high.
- R7: With test_i at 0, ld_o is selected by ld_sel_i as follows: 00 gives the AND of both channel lock indications, 01 gives channel 1 (index 0), 10 gives channel 2 (index 1), and 11 gives a constant high.
- R8: With test_i at 1, ld_o is selected by ld_sel_i as follows: 00 gives the reference rising-edge strobe, 01 gives the channel 1 divider strobe, 10 gives the channel 2 divider strobe, and 11 gives a constant low. A strobe is high while the input is 1 and was 0 at the previous clock edge.
- R9: ref_run_o is low exactly when both standby bits and ref_off_i are 1.
- R10: During reset, all command outputs are low and all qualifiers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Reference-divider output pulse |
| div_pulse_i | input | 2 | Channel-divider output pulses (bit 0 = channel 1) |
| invert_i | input | 1 | Command polarity swap |
| standby_i | input | 2 | Per-channel standby |
| ref_off_i | input | 1 | Reference-divider off request |
| test_i | input | 1 | Lock-pin test mode |
| ld_sel_i | input | 2 | Lock-pin source select |
| up_o | output | 2 | Advance command per channel |
| dn_o | output | 2 | Retard command per channel |
| ld_o | output | 1 | Lock pin |
| ref_run_o | output | 1 | Reference divider enable |

## Verification
The detectors are driven with several kinds of edge timing:
- Coincident edges, which show that there is no dead zone.
- Skews of one cycle in each direction, which must keep lock.
- A skew of two cycles, which is the smallest that breaks lock.
- Leading skews of three cycles with the polarity swapped, which separate the up path from the down path.
- A divider edge that never arrives, which exercises the lone-edge timeout separately from a completed bad comparison.

Every select code is tried in both lock-pin modes, with standby on each channel, so that each forced value can be told apart from a true lock state.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    LD_BOTH = 2'b00,
    LD_CH1  = 2'b01,
    LD_CH2  = 2'b10,
    LD_FIX  = 2'b11
  } ld_sel_e;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ref_rise_i,
  input  logic div_rise_i,
  input  logic invert_i,
  output logic ref_pend_o,
  output logic div_pend_o,
  output logic up_o,
  output logic dn_o
);
  logic ref_q, div_q, clr;

  assign clr = ref_q & div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      div_q <= 1'b0;
    end else if (hold_i || clr) begin
      ref_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      ref_q <= ref_q | ref_rise_i;
      div_q <= div_q | div_rise_i;
    end
  end

  assign ref_pend_o = ref_q;
  assign div_pend_o = div_q;
  assign up_o = invert_i ? div_q : ref_q;
  assign dn_o = invert_i ? ref_q : div_q;
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
  parameter int SKEW_LIM = 2,
  parameter int LOCK_N   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ref_pend_i,
  input  logic div_pend_i,
  output logic lock_o
);
  localparam int SKEW_W = $clog2(SKEW_LIM + 1);
  localparam int CNT_W  = $clog2(LOCK_N + 1);
  localparam logic [SKEW_W-1:0] SKEW_MAX = SKEW_W'(SKEW_LIM);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(LOCK_N);

  logic [SKEW_W-1:0] skew_q;
  logic [CNT_W-1:0]  cnt_q;
  logic one_side, done, miss;

  assign one_side = ref_pend_i ^ div_pend_i;
  assign done     = ref_pend_i & div_pend_i;
  assign miss     = (skew_q >= SKEW_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         skew_q <= '0;
    else if (hold_i || done)             skew_q <= '0;
    else if (one_side && !miss)          skew_q <= skew_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (hold_i || miss)             cnt_q <= '0;
    else if (done && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign lock_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pfd_ld_mux.sv
module pfd_ld_mux
  import pfd_lock_pkg::*;
(
  input  logic              test_i,
  input  logic [1:0]        sel_i,
  input  logic [NUM_CH-1:0] ch_lock_i,
  input  logic              ref_rise_i,
  input  logic [NUM_CH-1:0] div_rise_i,
  output logic              ld_o
);
  ld_sel_e sel;
  assign sel = ld_sel_e'(sel_i);

  always_comb begin
    if (!test_i) begin
      unique case (sel)
        LD_BOTH: ld_o = &ch_lock_i;
        LD_CH1:  ld_o = ch_lock_i[0];
        LD_CH2:  ld_o = ch_lock_i[1];
        default: ld_o = 1'b1;
      endcase
    end else begin
      unique case (sel)
        LD_BOTH: ld_o = ref_rise_i;
        LD_CH1:  ld_o = div_rise_i[0];
        LD_CH2:  ld_o = div_rise_i[1];
        default: ld_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
  import pfd_lock_pkg::*;
#(
  parameter int SKEW_LIM = 2,
  parameter int LOCK_N   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_pulse_i,
  input  logic [NUM_CH-1:0] div_pulse_i,
  input  logic              invert_i,
  input  logic [NUM_CH-1:0] standby_i,
  input  logic              ref_off_i,
  input  logic              test_i,
  input  logic [1:0]        ld_sel_i,
  output logic [NUM_CH-1:0] up_o,
  output logic [NUM_CH-1:0] dn_o,
  output logic              ld_o,
  output logic              ref_run_o
);
  logic              ref_rise;
  logic [NUM_CH-1:0] div_rise, ref_pend, div_pend, ch_lock, qual_lock;

  pfd_edge_det u_ref_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(ref_pulse_i), .rise_o(ref_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pfd_edge_det u_div_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(div_pulse_i[c]), .rise_o(div_rise[c])
    );

    pfd_core u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(standby_i[c]),
      .ref_rise_i(ref_rise), .div_rise_i(div_rise[c]), .invert_i(invert_i),
      .ref_pend_o(ref_pend[c]), .div_pend_o(div_pend[c]),
      .up_o(up_o[c]), .dn_o(dn_o[c])
    );

    pfd_lock_qual #(.SKEW_LIM(SKEW_LIM), .LOCK_N(LOCK_N)) u_qual (
      .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(standby_i[c]),
      .ref_pend_i(ref_pend[c]), .div_pend_i(div_pend[c]), .lock_o(qual_lock[c])
    );

    // standby channels never hold the pin low
    assign ch_lock[c] = standby_i[c] | qual_lock[c];
  end

  pfd_ld_mux u_ld_mux (
    .test_i(test_i), .sel_i(ld_sel_i), .ch_lock_i(ch_lock),
    .ref_rise_i(ref_rise), .div_rise_i(div_rise), .ld_o(ld_o)
  );

  assign ref_run_o = ~((&standby_i) & ref_off_i);
endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk
  import pfd_lock_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] standby_i,
  input logic              test_i,
  input logic [1:0]        ld_sel_i,
  input logic [NUM_CH-1:0] up_o,
  input logic [NUM_CH-1:0] dn_o,
  input logic              ld_o,
  input logic              ref_run_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R1
    pair_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_o[c] && dn_o[c]) |=> (!up_o[c] && !dn_o[c]));
    // R6
    standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      standby_i[c] |=> (!up_o[c] && !dn_o[c]));
  end

  // R7
  ld_forced_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && ld_sel_i == 2'b11) |-> ld_o);
  // R6
  ld_standby_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && ld_sel_i == 2'b01 && standby_i[0]) |-> ld_o);
  // R8
  ld_test_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && ld_sel_i == 2'b11) |-> !ld_o);
  // R9
  ref_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_run_o |-> (&standby_i));
endmodule

bind dual_pfd_lock dual_pfd_lock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i), .test_i(test_i),
  .ld_sel_i(ld_sel_i), .up_o(up_o), .dn_o(dn_o), .ld_o(ld_o), .ref_run_o(ref_run_o)
);

// File: tb/dual_pfd_lock_tb.sv
module dual_pfd_lock_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_pulse_i = 1'b0;
  logic [1:0] div_pulse_i = '0;
  logic       invert_i = 1'b0;
  logic [1:0] standby_i = '0;
  logic       ref_off_i = 1'b0;
  logic       test_i = 1'b0;
  logic [1:0] ld_sel_i = '0;
  logic [1:0] up_o, dn_o;
  logic       ld_o, ref_run_o;

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural model: edge timestamps per channel
  int  m_tr[2], m_td[2], m_cnt[2];
  int  m_n;
  bit  m_rp;
  bit  m_dp[2];
  logic cap_ld;
  logic [1:0] cap_up, cap_dn;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_pfd_lock dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_pulse_i(ref_pulse_i), .div_pulse_i(div_pulse_i),
    .invert_i(invert_i), .standby_i(standby_i), .ref_off_i(ref_off_i), .test_i(test_i),
    .ld_sel_i(ld_sel_i), .up_o(up_o), .dn_o(dn_o), .ld_o(ld_o), .ref_run_o(ref_run_o)
  );

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit re;
    bit de[2];
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        m_tr[c] = -1; m_td[c] = -1; m_cnt[c] = 0; m_dp[c] = 0;
      end
      m_rp = 0; m_n = 0;
      return;
    end
    re = ref_pulse_i && !m_rp;
    for (int c = 0; c < 2; c++) de[c] = div_pulse_i[c] && !m_dp[c];
    for (int c = 0; c < 2; c++) begin
      if (standby_i[c]) begin
        m_tr[c] = -1; m_td[c] = -1; m_cnt[c] = 0;
      end else if (m_tr[c] >= 0 && m_td[c] >= 0) begin
        int s;
        s = (m_tr[c] > m_td[c]) ? m_tr[c] - m_td[c] : m_td[c] - m_tr[c];
        if (s >= 2) m_cnt[c] = 0;
        else if (m_cnt[c] < 4) m_cnt[c]++;
        m_tr[c] = -1; m_td[c] = -1;
      end else begin
        int p;
        p = (m_tr[c] >= 0) ? m_tr[c] : m_td[c];
        if (p >= 0 && (m_n - p) >= 3) m_cnt[c] = 0;
        if (re && m_tr[c] < 0) m_tr[c] = m_n;
        if (de[c] && m_td[c] < 0) m_td[c] = m_n;
      end
    end
    m_rp = ref_pulse_i;
    for (int c = 0; c < 2; c++) m_dp[c] = div_pulse_i[c];
    m_n++;
  endtask

  task automatic compare_all();
    bit lk[2];
    logic e_ld;
    for (int c = 0; c < 2; c++) begin
      logic eu, ed;
      eu = invert_i ? (m_td[c] >= 0) : (m_tr[c] >= 0);
      ed = invert_i ? (m_tr[c] >= 0) : (m_td[c] >= 0);
      chk(invert_i ? "R2 up" : "R1 up", up_o[c], eu);
      chk(invert_i ? "R2 dn" : "R1 dn", dn_o[c], ed);
      lk[c] = standby_i[c] || (m_cnt[c] >= 4);
    end
    if (!test_i) begin
      case (ld_sel_i)
        2'b00: e_ld = lk[0] & lk[1];
        2'b01: e_ld = lk[0];
        2'b10: e_ld = lk[1];
        default: e_ld = 1'b1;
      endcase
      chk("R4/R7 ld", ld_o, e_ld);
    end else begin
      case (ld_sel_i)
        2'b00: e_ld = ref_pulse_i && !m_rp;
        2'b01: e_ld = div_pulse_i[0] && !m_dp[0];
        2'b10: e_ld = div_pulse_i[1] && !m_dp[1];
        default: e_ld = 1'b0;
      endcase
      chk("R8 ld", ld_o, e_ld);
    end
    chk("R9 ref_run", ref_run_o, !(standby_i == 2'b11 && ref_off_i));
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare_all();
  endtask

  // one reference period; divider c edge at cycle 4+off[c], off 99 = absent
  task automatic period(int o1, int o2);
    for (int i = 0; i < 16; i++) begin
      ref_pulse_i    = (i == 4);
      div_pulse_i[0] = (i == 4 + o1);
      div_pulse_i[1] = (i == 4 + o2);
      if (i == 4) begin
        #1 cap_ld = ld_o;
      end
      cyc();
      if (i == 4) begin
        cap_up = up_o; cap_dn = dn_o;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) cyc();
    // R10 reset state
    chk("R10 up", up_o[0] | up_o[1], 1'b0);
    chk("R10 dn", dn_o[0] | dn_o[1], 1'b0);
    chk("R10 ld", ld_o, 1'b0);
    chk("R10 ref_run", ref_run_o, 1'b1);
    rst_ni = 1'b1;
    cyc();

    // R4: three aligned comparisons not enough, fourth locks
    for (int k = 0; k < 3; k++) period(0, 0);
    chk("R4 ld after 3", ld_o, 1'b0);
    period(0, 0);
    chk("R4 ld after 4", ld_o, 1'b1);

    // R3: one-cycle skew either way keeps lock
    period(1, -1);
    period(-1, 1);
    chk("R3 ld skew 1", ld_o, 1'b1);

    // R5: skew of 2 on channel 1 drops lock
    period(2, 0);
    chk("R5 ld both", ld_o, 1'b0);
    ld_sel_i = 2'b01; cyc();
    chk("R7 ld ch1", ld_o, 1'b0);
    ld_sel_i = 2'b10; cyc();
    chk("R7 ld ch2", ld_o, 1'b1);
    ld_sel_i = 2'b11; cyc();
    chk("R7 ld fixed", ld_o, 1'b1);

    // R5: missing divider edge on channel 2 drops its lock
    period(0, 99);
    ld_sel_i = 2'b10; cyc();
    chk("R5 ld ch2 lone edge", ld_o, 1'b0);

    // R2: inverted polarity with ref leading by 3
    invert_i = 1'b1;
    period(3, 3);
    chk("R2 up swapped", cap_up[0], 1'b0);
    chk("R2 dn swapped", cap_dn[0], 1'b1);
    invert_i = 1'b0;
    period(-3, -3);

    // R6: standby channel 1
    standby_i = 2'b01; ld_sel_i = 2'b01;
    period(0, 0);
    chk("R6 up quiet", cap_up[0], 1'b0);
    chk("R6 dn quiet", cap_dn[0], 1'b0);
    chk("R6 ld high", ld_o, 1'b1);
    standby_i = 2'b00; cyc();
    chk("R6 ld restart", ld_o, 1'b0);

    // R8: test mode
    test_i = 1'b1; ld_sel_i = 2'b00;
    period(0, 0);
    chk("R8 ref strobe", cap_ld, 1'b1);
    ld_sel_i = 2'b10;
    period(0, 99);
    chk("R8 ch2 strobe absent", cap_ld, 1'b0);
    ld_sel_i = 2'b11; cyc();
    chk("R8 fixed low", ld_o, 1'b0);
    test_i = 1'b0; ld_sel_i = 2'b00;

    // R9: reference run flag
    ref_off_i = 1'b1; standby_i = 2'b10; cyc();
    chk("R9 one standby", ref_run_o, 1'b1);
    standby_i = 2'b11; cyc();
    chk("R9 all off", ref_run_o, 1'b0);
    ref_off_i = 1'b0; standby_i = 2'b00; cyc();

    // R1: coincident edges give a one-cycle pulse on both
    ref_pulse_i = 1'b1; div_pulse_i = 2'b01; cyc();
    chk("R1 coincident up", up_o[0], 1'b1);
    chk("R1 coincident dn", dn_o[0], 1'b1);
    ref_pulse_i = 1'b0; div_pulse_i = 2'b00; cyc();
    chk("R1 cleared up", up_o[0], 1'b0);
    chk("R1 cleared dn", dn_o[0], 1'b0);
    for (int i = 0; i < 8; i++) cyc();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule